// File: doc/BRIEF.md
# Quadrature and Pulse-Direction Count Decoder

This block turns the two raw channel inputs of an incremental encoder, A and B, into single-cycle count strobes (`count_up`, `count_down`) for a separate position counter. Each input is first brought into the clock domain by a two-flop synchroniser. It then passes a digital noise filter whose sampling rate comes from an 8-bit prescaler. The filtered pair drives an edge decoder that works in one of four functions. These are pulse/direction, where A is the clock and B the direction, and quadrature counting at one, two or four counts per encoder cycle.

The block keeps a direction flag that follows the last emitted count. It also keeps a sticky noise-error flag, which is set when both filtered inputs change in the same cycle while a quadrature function is selected. The error stays set until `err_clear` is pulsed. A count enable gates all strobes. The counter register and any bus access are left to the surrounding logic.

Top module: `quad_count_decoder`

## Requirements
- R1: `mode` selects the function: 2'b00 pulse/direction, 2'b01 quadrature x1, 2'b10 quadrature x2, 2'b11 quadrature x4.
- R2: In pulse/direction mode, each rising edge of filtered A produces one strobe: `count_up` when filtered B is 1, `count_down` when it is 0. B changes alone produce nothing.
- R3: Forward motion means the filtered (A,B) pair steps 00→10→11→01→00, and backward motion is the reverse. In x1 mode a forward step in which A rises gives one `count_up`. A backward step in which A falls gives one `count_down`. No other step counts.
- R4: In x2 mode every legal step in which A changes counts, up for forward and down for backward.
- R5: In x4 mode every legal step counts, up for forward and down for backward.
- R6: `dir_up` is 1 after reset, becomes 1 with each `count_up` and 0 with each `count_down`, and holds otherwise.
- R7: A filtered level takes a new value only on a filter tick, and only after the synchronised input has shown that value on two consecutive ticks. A pulse seen on a single tick is rejected.
- R8: The filter ticks once every `psc_value`+1 clocks for the value last loaded with `psc_load`. After reset the prescaler is 0, so there is a tick every clock. A load restarts the tick period and gives a tick in the following cycle.
- R9: In any quadrature mode, a step in which A and B change together produces no strobe and sets `noise_err`.
- R10: `noise_err` is 0 after reset and stays set until `err_clear`. When a new illegal step and `err_clear` fall in the same cycle, the flag stays set.
- R11: While `count_en` is 0, no strobe is produced and `dir_up` does not change.
- R12: With the prescaler at 0, a strobe rises on the fifth rising clock edge after the raw input changes. It lasts one cycle, and `count_up` and `count_down` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enc_a | input | 1 | Raw channel A (pulse input in pulse/direction mode) |
| enc_b | input | 1 | Raw channel B (direction input in pulse/direction mode) |
| mode | input | 2 | Decode function select (R1 encoding) |
| count_en | input | 1 | Gates the count strobes |
| psc_value | input | 8 | Filter prescaler value |
| psc_load | input | 1 | Loads `psc_value` into the prescaler |
| err_clear | input | 1 | Clears the sticky noise-error flag |
| count_up | output | 1 | One-cycle increment strobe |
| count_down | output | 1 | One-cycle decrement strobe |
| dir_up | output | 1 | Direction of the last count, 1 = up |
| noise_err | output | 1 | Sticky illegal-transition flag |

## Verification
Two functions can meet in one cycle: detecting an illegal simultaneous A/B step, which sets the error flag, and a software clear of that flag. The bench provokes the meeting by moving both inputs at once and raising `err_clear` exactly at the fifth clock edge, when the illegal step is decoded. It then expects the flag still set, and a later lone clear to drop it. The same per-clock reference model also judges cycles where a count strobe and a direction update coincide. In those cycles `dir_up` must already show the new direction together with the strobe.

// File: rtl/qdec_pkg.sv
package qdec_pkg;

  typedef enum logic [1:0] {
    MODE_PULSE_DIR = 2'b00,
    MODE_QX1       = 2'b01,
    MODE_QX2       = 2'b10,
    MODE_QX4       = 2'b11
  } qmode_e;

  typedef enum logic [1:0] {
    STEP_NONE = 2'b00,
    STEP_FWD  = 2'b01,
    STEP_BAD  = 2'b10,
    STEP_BACK = 2'b11
  } step_e;

  // Position of an (A,B) pair on the forward cycle 00,10,11,01.
  function automatic logic [1:0] phase_of(input logic a, input logic b);
    return {b, a ^ b};
  endfunction

  // Classify the move between two phases by their difference modulo four.
  function automatic step_e classify(input logic [1:0] old_ph,
                                     input logic [1:0] new_ph);
    logic [1:0] diff;
    diff = new_ph - old_ph;
    return step_e'(diff);
  endfunction

endpackage

// File: rtl/qdec_tick.sv
module qdec_tick #(
  parameter int PSC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PSC_W-1:0] psc_value,
  input  logic             psc_load,
  output logic             tick
);
  logic [PSC_W-1:0] psc_q;
  logic [PSC_W-1:0] cnt_q;

  assign tick = (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      psc_q <= '0;
      cnt_q <= '0;
    end else if (psc_load) begin
      psc_q <= psc_value;
      cnt_q <= '0;
    end else if (tick) begin
      cnt_q <= psc_q;
    end else begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assert_load_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
    psc_load |=> tick);

  assert_zero_every_cycle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && psc_q == '0 && !psc_load) |=> tick);

endmodule

// File: rtl/qdec_filter.sv
module qdec_filter #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic raw,
  output logic level
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   sample_q;
  logic                   synced;
  logic                   agree;

  assign synced = sync_q[SYNC_STAGES-1];
  assign agree  = (synced == sample_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q   <= '0;
      sample_q <= 1'b0;
      level    <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], raw};
      if (tick) begin
        sample_q <= synced;
        if (agree) level <= synced;
      end
    end
  end

  assert_hold_between_ticks_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(level));

  assert_needs_two_samples_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !agree) |=> $stable(level));

endmodule

// File: rtl/qdec_decode.sv
module qdec_decode
  import qdec_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode,
  input  logic       count_en,
  input  logic       err_clear,
  input  logic       lvl_a,
  input  logic       lvl_b,
  output logic       count_up,
  output logic       count_down,
  output logic       dir_up,
  output logic       noise_err
);
  logic  a_q, b_q;
  logic  a_rise, a_fall, a_chg;
  logic  quad_mode;
  step_e step;
  logic  bad_step;
  logic  want_up, want_dn;
  logic  hit_up, hit_dn;

  assign a_rise    = lvl_a & ~a_q;
  assign a_fall    = ~lvl_a & a_q;
  assign a_chg     = lvl_a ^ a_q;
  assign quad_mode = (mode != MODE_PULSE_DIR);
  assign step      = classify(phase_of(a_q, b_q), phase_of(lvl_a, lvl_b));
  assign bad_step  = quad_mode && (step == STEP_BAD);

  always_comb begin
    want_up = 1'b0;
    want_dn = 1'b0;
    unique case (mode)
      MODE_PULSE_DIR: begin
        want_up = a_rise & lvl_b;
        want_dn = a_rise & ~lvl_b;
      end
      MODE_QX1: begin
        want_up = (step == STEP_FWD)  && a_rise;
        want_dn = (step == STEP_BACK) && a_fall;
      end
      MODE_QX2: begin
        want_up = (step == STEP_FWD)  && a_chg;
        want_dn = (step == STEP_BACK) && a_chg;
      end
      default: begin
        want_up = (step == STEP_FWD);
        want_dn = (step == STEP_BACK);
      end
    endcase
  end

  assign hit_up = want_up & count_en;
  assign hit_dn = want_dn & count_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q        <= 1'b0;
      b_q        <= 1'b0;
      count_up   <= 1'b0;
      count_down <= 1'b0;
      dir_up     <= 1'b1;
      noise_err  <= 1'b0;
    end else begin
      a_q        <= lvl_a;
      b_q        <= lvl_b;
      count_up   <= hit_up;
      count_down <= hit_dn;
      if (hit_up)      dir_up <= 1'b1;
      else if (hit_dn) dir_up <= 1'b0;
      if (bad_step)       noise_err <= 1'b1;
      else if (err_clear) noise_err <= 1'b0;
    end
  end

  assert_pd_rise_counts_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_PULSE_DIR && a_rise && count_en) |=> (count_up || count_down));

  assert_bad_no_count_R9: assert property (@(posedge clk) disable iff (!rst_n)
    bad_step |=> (!count_up && !count_down));

  assert_bad_sets_err_R9: assert property (@(posedge clk) disable iff (!rst_n)
    bad_step |=> noise_err);

  assert_err_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (noise_err && !err_clear) |=> noise_err);

  assert_gate_off_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !count_en |=> (!count_up && !count_down && $stable(dir_up)));

  assert_dir_follows_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (count_up |-> dir_up) and (count_down |-> !dir_up));

  assert_one_cycle_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !(count_up && count_down));

endmodule

// File: rtl/quad_count_decoder.sv
module quad_count_decoder #(
  parameter int PSC_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enc_a,
  input  logic             enc_b,
  input  logic [1:0]       mode,
  input  logic             count_en,
  input  logic [PSC_W-1:0] psc_value,
  input  logic             psc_load,
  input  logic             err_clear,
  output logic             count_up,
  output logic             count_down,
  output logic             dir_up,
  output logic             noise_err
);
  localparam int NUM_IN = 2;

  logic              tick;
  logic [NUM_IN-1:0] raw_vec;
  logic [NUM_IN-1:0] lvl_vec;

  assign raw_vec = {enc_b, enc_a};

  qdec_tick #(.PSC_W(PSC_W)) u_tick (
    .clk       (clk),
    .rst_n     (rst_n),
    .psc_value (psc_value),
    .psc_load  (psc_load),
    .tick      (tick)
  );

  for (genvar gi = 0; gi < NUM_IN; gi++) begin : g_in
    qdec_filter #(.SYNC_STAGES(SYNC_STAGES)) u_filter (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (tick),
      .raw   (raw_vec[gi]),
      .level (lvl_vec[gi])
    );
  end

  qdec_decode u_decode (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode       (mode),
    .count_en   (count_en),
    .err_clear  (err_clear),
    .lvl_a      (lvl_vec[0]),
    .lvl_b      (lvl_vec[1]),
    .count_up   (count_up),
    .count_down (count_down),
    .dir_up     (dir_up),
    .noise_err  (noise_err)
  );

endmodule

// File: tb/test_quad_count_decoder.sv
`timescale 1ns/1ps
module test_quad_count_decoder;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       enc_a = 1'b0, enc_b = 1'b0;
  logic [1:0] mode = 2'b00;
  logic       count_en = 1'b1;
  logic [7:0] psc_value = 8'd0;
  logic       psc_load = 1'b0;
  logic       err_clear = 1'b0;
  logic       count_up, count_down, dir_up, noise_err;

  int total = 0, bad = 0, n_up = 0, n_dn = 0;
  bit done = 1'b0;
  string cur_tag = "R12";

  always #2.5 clk = ~clk;

  quad_count_decoder i_quad_count_decoder (
    .clk(clk), .rst_n(rst_n), .enc_a(enc_a), .enc_b(enc_b), .mode(mode),
    .count_en(count_en), .psc_value(psc_value), .psc_load(psc_load),
    .err_clear(err_clear), .count_up(count_up), .count_down(count_down),
    .dir_up(dir_up), .noise_err(noise_err)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Behavioural reference model, advanced once per rising edge.
  bit m_s1[2], m_s2[2], m_smp[2], m_f[2], m_p[2];
  int m_psc = 0, m_cnt = 0;
  bit m_up = 0, m_dn = 0, m_dir = 1, m_err = 0;
  int po, pn, d;
  bit arise, afall, achg, ex_up, ex_dn, tk;

  function automatic int ph(bit a, bit b);
    case ({a, b})
      2'b00:   return 0;
      2'b10:   return 1;
      2'b11:   return 2;
      default: return 3;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (m_s1[i]) begin
        m_s1[i] = 0; m_s2[i] = 0; m_smp[i] = 0; m_f[i] = 0; m_p[i] = 0;
      end
      m_psc = 0; m_cnt = 0; m_up = 0; m_dn = 0; m_dir = 1; m_err = 0;
    end else begin
      po = ph(m_p[0], m_p[1]);
      pn = ph(m_f[0], m_f[1]);
      d  = (pn - po + 4) % 4;
      arise = m_f[0] && !m_p[0];
      afall = !m_f[0] && m_p[0];
      achg  = m_f[0] != m_p[0];
      ex_up = 0; ex_dn = 0;
      case (mode)
        2'b00: if (arise) begin if (m_f[1]) ex_up = 1; else ex_dn = 1; end
        2'b01: begin ex_up = (d == 1) && arise; ex_dn = (d == 3) && afall; end
        2'b10: begin ex_up = (d == 1) && achg;  ex_dn = (d == 3) && achg;  end
        default: begin ex_up = (d == 1); ex_dn = (d == 3); end
      endcase
      if (!count_en) begin ex_up = 0; ex_dn = 0; end
      m_up = ex_up; m_dn = ex_dn;
      if (ex_up) m_dir = 1; else if (ex_dn) m_dir = 0;
      if (mode != 2'b00 && d == 2) m_err = 1; else if (err_clear) m_err = 0;
      m_p = m_f;
      tk = (m_cnt == 0);
      for (int i = 0; i < 2; i++) begin
        if (tk) begin
          if (m_s2[i] == m_smp[i]) m_f[i] = m_s2[i];
          m_smp[i] = m_s2[i];
        end
      end
      if (psc_load) begin m_psc = psc_value; m_cnt = 0; end
      else if (tk) m_cnt = m_psc;
      else m_cnt = m_cnt - 1;
      m_s2 = m_s1;
      m_s1[0] = enc_a; m_s1[1] = enc_b;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done)
      chk({count_up, count_down, dir_up, noise_err} == {m_up, m_dn, m_dir, m_err},
          {cur_tag, " model"}, {count_up, count_down, dir_up, noise_err},
          {m_up, m_dn, m_dir, m_err});
  end

  always @(posedge clk) begin
    #1;
    if (count_up) n_up++;
    if (count_down) n_dn++;
  end

  task automatic hold_ab(input bit a, input bit b, input int cyc);
    @(negedge clk);
    enc_a = a; enc_b = b;
    repeat (cyc) @(negedge clk);
  endtask

  task automatic zero_counts();
    n_up = 0; n_dn = 0;
  endtask

  task automatic expect_counts(input int up, input int dn, input string tag);
    chk(n_up == up, {tag, " up count"}, n_up, up);
    chk(n_dn == dn, {tag, " down count"}, n_dn, dn);
    zero_counts();
  endtask

  task automatic fwd_cycle(input int cyc);
    hold_ab(1, 0, cyc); hold_ab(1, 1, cyc); hold_ab(0, 1, cyc); hold_ab(0, 0, cyc);
  endtask

  task automatic back_cycle(input int cyc);
    hold_ab(0, 1, cyc); hold_ab(1, 1, cyc); hold_ab(1, 0, cyc); hold_ab(0, 0, cyc);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(count_up == 0 && count_down == 0, "R12 reset strobes", count_up + count_down, 0);
    chk(dir_up == 1, "R6 reset direction", dir_up, 1);
    chk(noise_err == 0, "R10 reset error", noise_err, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    zero_counts();

    // R2 pulse/direction: B changes alone must not count
    cur_tag = "R2"; mode = 2'b00;
    hold_ab(0, 1, 8);
    for (int k = 0; k < 3; k++) begin hold_ab(1, 1, 8); hold_ab(0, 1, 8); end
    expect_counts(3, 0, "R2 b=1");
    hold_ab(0, 0, 8);
    for (int k = 0; k < 2; k++) begin hold_ab(1, 0, 8); hold_ab(0, 0, 8); end
    expect_counts(0, 2, "R2 b=0");
    chk(dir_up == 0, "R6 direction after down", dir_up, 0);

    // R1/R3 x1
    cur_tag = "R3"; mode = 2'b01;
    fwd_cycle(8); fwd_cycle(8);
    expect_counts(2, 0, "R3 x1 forward");
    back_cycle(8);
    expect_counts(0, 1, "R3 x1 backward");

    // R4 x2
    cur_tag = "R4"; mode = 2'b10;
    fwd_cycle(8);
    expect_counts(2, 0, "R4 x2 forward");
    back_cycle(8);
    expect_counts(0, 2, "R4 x2 backward");

    // R5 x4
    cur_tag = "R5"; mode = 2'b11;
    fwd_cycle(8);
    expect_counts(4, 0, "R5 x4 forward");
    chk(dir_up == 1, "R6 direction after up", dir_up, 1);
    back_cycle(8);
    expect_counts(0, 4, "R5 x4 backward");
    fwd_cycle(8);
    zero_counts();

    // R12 latency from raw edge to strobe
    cur_tag = "R12";
    @(negedge clk); enc_a = 1;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk(count_up == 0, "R12 strobe too early", count_up, 0);
    end
    @(negedge clk);
    chk(count_up == 1, "R12 strobe at fifth edge", count_up, 1);
    @(negedge clk);
    chk(count_up == 0, "R12 strobe one cycle", count_up, 0);
    hold_ab(1, 1, 8); hold_ab(0, 1, 8); hold_ab(0, 0, 8);
    zero_counts();

    // R11 enable low
    cur_tag = "R11"; count_en = 0;
    back_cycle(8);
    expect_counts(0, 0, "R11 gated");
    chk(dir_up == 1, "R11 direction held", dir_up, 1);
    count_en = 1;

    // R7 single-cycle glitch
    cur_tag = "R7";
    @(negedge clk); enc_a = 1;
    @(negedge clk); enc_a = 0;
    repeat (10) @(negedge clk);
    expect_counts(0, 0, "R7 glitch rejected");
    chk(noise_err == 0, "R7 glitch no error", noise_err, 0);

    // R9/R10 illegal step with clear in the same cycle
    cur_tag = "R9";
    @(negedge clk); enc_a = 1; enc_b = 1;
    repeat (4) @(negedge clk);
    err_clear = 1;
    @(negedge clk); err_clear = 0;
    chk(noise_err == 1, "R10 set wins over clear", noise_err, 1);
    repeat (10) @(negedge clk);
    chk(noise_err == 1, "R10 error sticky", noise_err, 1);
    expect_counts(0, 0, "R9 illegal no count");
    @(negedge clk); err_clear = 1;
    @(negedge clk); err_clear = 0;
    chk(noise_err == 0, "R10 clear", noise_err, 0);
    hold_ab(0, 1, 8); hold_ab(0, 0, 8);
    expect_counts(2, 0, "R9 legal after illegal");

    // R8 prescaler: three-cycle glitch rejected, slow steps counted
    cur_tag = "R8";
    @(negedge clk); psc_value = 8'd3; psc_load = 1;
    @(negedge clk); psc_load = 0;
    @(negedge clk); enc_a = 1;
    repeat (3) @(negedge clk);
    enc_a = 0;
    repeat (20) @(negedge clk);
    expect_counts(0, 0, "R8 slow filter rejects short pulse");
    fwd_cycle(20);
    expect_counts(4, 0, "R8 slow filter counts");
    chk(noise_err == 0, "R8 no error", noise_err, 0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(100000 * 5);
    if (!done) begin
      done = 1'b1;
      total++; bad++;
      $display("FAIL watchdog R12 actual=0 expected=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule